// File: doc/BRIEF.md
# Conditional Microprogram Next-Address Sequencer

This block produces the control-store address for a pipelined microprogrammed controller. On every clock it tests one of sixteen external condition lines, optionally inverted by a polarity bit taken from the microword. It then carries out one of sixteen sequencing functions, which choose among the incremented address, a loadable branch register, a literal carried in the microword, the top of a small return stack, and zero. The registered address output feeds the control-store memory directly. The memory, the pipeline register and the ALU stay outside the block. The ALU status flags arrive on the condition inputs already registered, so a conditional function always tests the flags of the previous microinstruction.

The branch register is filled from the narrow internal data bus in two pieces. The low byte and the high part each have their own destination strobe, and a loaded value is used from the next cycle onward. The return stack gives subroutine linkage four levels deep. A load-mode input is used while the control store is being written. It overrides the function code so that the address first goes to zero and then climbs by one on every further write cycle.

Top module: `useq_next_addr`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets addr_out to 0 and empties the return stack. A pop issued right after reset returns address 0.
- R2: The tested condition is cond_in[cond_sel] XOR cond_pol. With cond_pol=1, a low condition line counts as true.
- R3: Function 0 (continue) loads addr_out+1 at the next edge. The address wraps from 0xFFF to 0x000.
- R4: The unconditional functions are: 1 jumps to literal, 2 jumps to the branch register, 3 jumps to address 0, 9 pops the stack into the address, and 10 pushes addr_out+1 and then continues.
- R5: The conditional jumps are: 4 goes to the branch register, 5 goes to literal and 15 goes to 0 when the tested condition is true. Each one continues (addr_out+1) when the condition is false.
- R6: Function 6 (call literal) and function 7 (call branch register) push addr_out+1 and jump when the condition is true. Function 8 (conditional return) pops the stack into the address when the condition is true.
- R7: A push onto a full 4-entry stack overwrites the oldest entry. The four most recent return addresses then come back in last-in, first-out order.
- R8: A pop from an empty stack leaves the stack unchanged and returns the entry that was removed most recently.
- R9: br_lo_stb loads bus_data into branch-register bits 7:0, and br_hi_stb loads bus_data[3:0] into bits 11:8. Each strobe acts at the clock edge. Without a strobe the register holds its value, whatever is on bus_data.
- R10: While load_mode is high, the function code is ignored. The first cycle with load_mode high forces a jump to 0, every later cycle forces continue, and the stack is never pushed or popped.
- R11: Function 12 (wait) holds addr_out while the condition is false and continues when it is true. Function 13 jumps to the top of the stack without popping when the condition is true. Function 14 goes to the branch register when true and to literal when false. Function 11 discards the top entry when true. All of them continue otherwise, except functions 12 and 14 as stated.
- R12: A conditional call, return or discard whose condition is false leaves the stack unchanged and continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_in | input | 16 | Condition lines, including the registered ALU flags |
| cond_sel | input | 4 | Microword field that picks the condition line to test |
| cond_pol | input | 1 | Microword polarity bit, XORed with the selected line |
| func | input | 4 | Microword next-address function code |
| literal | input | 12 | Microword literal address |
| bus_data | input | 8 | Internal data bus feeding the branch register |
| br_lo_stb | input | 1 | Destination strobe for branch-register bits 7:0 |
| br_hi_stb | input | 1 | Destination strobe for branch-register bits 11:8 |
| load_mode | input | 1 | Control-store write mode, overrides the function code |
| addr_out | output | 12 | Registered control-store address |

## Verification
The assertions assume that every input is a known value on each rising edge and that load_mode does not go high in the first cycle after reset. The assertion that checks the continuation during load mode also leaves out the edge just after reset. The bench changes inputs only on falling edges and releases reset before it raises load_mode. Each scenario sets the condition vector, the strobes and the function code together in one place, so the assertions see only legal, fully defined encodings.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef enum logic [3:0] {
      F_CONT      = 4'd0,
      F_JLIT      = 4'd1,
      F_JBR       = 4'd2,
      F_JZERO     = 4'd3,
      F_CJBR      = 4'd4,
      F_CJLIT     = 4'd5,
      F_CCALL_LIT = 4'd6,
      F_CCALL_BR  = 4'd7,
      F_CRET      = 4'd8,
      F_RET       = 4'd9,
      F_PUSH      = 4'd10,
      F_CPOP      = 4'd11,
      F_CWAIT     = 4'd12,
      F_CJTOS     = 4'd13,
      F_CJ2WAY    = 4'd14,
      F_CJZERO    = 4'd15
   } seq_fn_e;

endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux #(
   parameter int N_COND = 16,
   localparam int SEL_W = $clog2(N_COND)
) (
   input  logic [N_COND-1:0] cond_in,
   input  logic [SEL_W-1:0]  sel,
   input  logic              pol,
   output logic              tst
);

   generate
      if (N_COND < 2 || (1 << SEL_W) != N_COND) begin : g_bad_cond
         $error("N_COND must be a power of two and at least 2");
      end
   endgenerate

   logic picked;

   always_comb begin
      picked = cond_in[sel];
      tst    = picked ^ pol;
   end

endmodule

// File: rtl/useq_branch_reg.sv
module useq_branch_reg #(
   parameter int ADDR_W = 12,
   parameter int BUS_W  = 8,
   localparam int HI_W  = ADDR_W - BUS_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [BUS_W-1:0]  bus_data,
   input  logic              lo_stb,
   input  logic              hi_stb,
   output logic [ADDR_W-1:0] br_val
);

   generate
      if (HI_W < 1 || HI_W > BUS_W) begin : g_bad_width
         $error("ADDR_W must exceed BUS_W and be at most twice BUS_W");
      end
   endgenerate

   logic [BUS_W-1:0] lo_q;
   logic [HI_W-1:0]  hi_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_q <= '0;
      end else if (lo_stb) begin
         lo_q <= bus_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_q <= '0;
      end else if (hi_stb) begin
         hi_q <= bus_data[HI_W-1:0];
      end
   end

   assign br_val = {hi_q, lo_q};

   // R9
   br_lo_load_chk: assert property (@(posedge clk) disable iff (rst)
      lo_stb |=> br_val[BUS_W-1:0] == $past(bus_data));

   // R9
   br_hi_load_chk: assert property (@(posedge clk) disable iff (rst)
      hi_stb |=> br_val[ADDR_W-1:BUS_W] == $past(bus_data[HI_W-1:0]));

   // R9
   br_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!lo_stb && !hi_stb) |=> $stable(br_val));

endmodule

// File: rtl/useq_ret_stack.sv
module useq_ret_stack #(
   parameter int WIDTH = 12,
   parameter int DEPTH = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] tos
);

   generate
      if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two and at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] PONE = PTR_W'(1);
   localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0] sp_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PTR_W-1:0] sp_up;
   logic [PTR_W-1:0] wr_ptr;

   always_comb begin
      sp_up  = sp_q + PONE;
      wr_ptr = (cnt_q == '0) ? sp_q : sp_up;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= '0;
         end
      end else if (push) begin
         mem_q[wr_ptr] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sp_q  <= '0;
         cnt_q <= '0;
      end else if (push) begin
         sp_q <= wr_ptr;
         if (cnt_q != FULL) begin
            cnt_q <= cnt_q + CONE;
         end
      end else if (pop) begin
         if (cnt_q > CONE) begin
            sp_q  <= sp_q - PONE;
            cnt_q <= cnt_q - CONE;
         end else if (cnt_q == CONE) begin
            cnt_q <= '0;
         end
      end
   end

   assign tos = mem_q[sp_q];

   // R7
   stk_full_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (push && cnt_q == FULL) |=> cnt_q == FULL);

   // R7
   stk_push_top_chk: assert property (@(posedge clk) disable iff (rst)
      push |=> tos == $past(din));

   // R8
   stk_empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
      (pop && !push && cnt_q == '0) |=> ($stable(sp_q) && $stable(tos)));

   // R12
   stk_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!push && !pop) |=> ($stable(sp_q) && $stable(cnt_q)));

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
   parameter int ADDR_W = 12,
   parameter int BUS_W  = 8,
   parameter int N_COND = 16,
   parameter int DEPTH  = 4,
   localparam int SEL_W = $clog2(N_COND)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_COND-1:0] cond_in,
   input  logic [SEL_W-1:0]  cond_sel,
   input  logic              cond_pol,
   input  logic [3:0]        func,
   input  logic [ADDR_W-1:0] literal,
   input  logic [BUS_W-1:0]  bus_data,
   input  logic              br_lo_stb,
   input  logic              br_hi_stb,
   input  logic              load_mode,
   output logic [ADDR_W-1:0] addr_out
);
   import useq_pkg::*;

   localparam logic [ADDR_W-1:0] AONE = ADDR_W'(1);

   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] nxt;
   logic [ADDR_W-1:0] pc_inc;
   logic [ADDR_W-1:0] br_val;
   logic [ADDR_W-1:0] tos;
   logic              tst;
   logic              load_q;
   logic              do_push;
   logic              do_pop;
   seq_fn_e           eff_fn;

   useq_cond_mux #(.N_COND(N_COND)) u_cond (
      .cond_in (cond_in),
      .sel     (cond_sel),
      .pol     (cond_pol),
      .tst     (tst)
   );

   useq_branch_reg #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_br (
      .clk      (clk),
      .rst      (rst),
      .bus_data (bus_data),
      .lo_stb   (br_lo_stb),
      .hi_stb   (br_hi_stb),
      .br_val   (br_val)
   );

   useq_ret_stack #(.WIDTH(ADDR_W), .DEPTH(DEPTH)) u_stk (
      .clk  (clk),
      .rst  (rst),
      .push (do_push),
      .pop  (do_pop),
      .din  (pc_inc),
      .tos  (tos)
   );

   // load mode: the first write cycle forces zero, later ones continue
   always_comb begin
      if (load_mode) begin
         eff_fn = load_q ? F_CONT : F_JZERO;
      end else begin
         eff_fn = seq_fn_e'(func);
      end
   end

   always_comb begin
      pc_inc  = addr_q + AONE;
      nxt     = pc_inc;
      do_push = 1'b0;
      do_pop  = 1'b0;
      case (eff_fn)
         F_CONT:      ;
         F_JLIT:      nxt = literal;
         F_JBR:       nxt = br_val;
         F_JZERO:     nxt = '0;
         F_CJBR:      if (tst) nxt = br_val;
         F_CJLIT:     if (tst) nxt = literal;
         F_CCALL_LIT: if (tst) begin
                         nxt     = literal;
                         do_push = 1'b1;
                      end
         F_CCALL_BR:  if (tst) begin
                         nxt     = br_val;
                         do_push = 1'b1;
                      end
         F_CRET:      if (tst) begin
                         nxt    = tos;
                         do_pop = 1'b1;
                      end
         F_RET:       begin
                         nxt    = tos;
                         do_pop = 1'b1;
                      end
         F_PUSH:      do_push = 1'b1;
         F_CPOP:      if (tst) do_pop = 1'b1;
         F_CWAIT:     if (!tst) nxt = addr_q;
         F_CJTOS:     if (tst) nxt = tos;
         F_CJ2WAY:    nxt = tst ? br_val : literal;
         F_CJZERO:    if (tst) nxt = '0;
         default:     ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         load_q <= 1'b0;
      end else begin
         addr_q <= nxt;
         load_q <= load_mode;
      end
   end

   assign addr_out = addr_q;

   // R1
   rst_addr_chk: assert property (@(posedge clk)
      rst |=> addr_out == '0);

   // R3
   cont_inc_chk: assert property (@(posedge clk) disable iff (rst)
      (!load_mode && func == 4'd0) |=> addr_out == $past(addr_out) + AONE);

   // R10
   load_zero_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(load_mode) |=> addr_out == '0);

   // R10
   load_step_chk: assert property (@(posedge clk) disable iff (rst)
      (load_mode && $past(load_mode) && !$past(rst))
         |=> addr_out == $past(addr_out) + AONE);

   // R10
   load_no_stack_chk: assert property (@(posedge clk) disable iff (rst)
      load_mode |-> (!do_push && !do_pop));

   // R2, R5
   cj_br_taken_chk: assert property (@(posedge clk) disable iff (rst)
      (!load_mode && func == 4'd4 && (cond_in[cond_sel] ^ cond_pol))
         |=> addr_out == $past(br_val));

   // R11
   wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!load_mode && func == 4'd12 && !(cond_in[cond_sel] ^ cond_pol))
         |=> $stable(addr_out));

endmodule

// File: tb/test_useq_next_addr.sv
module test_useq_next_addr;

   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] cond_in;
   logic [3:0]  cond_sel;
   logic        cond_pol;
   logic [3:0]  func;
   logic [11:0] literal;
   logic [7:0]  bus_data;
   logic        br_lo_stb;
   logic        br_hi_stb;
   logic        load_mode;
   logic [11:0] addr_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   useq_next_addr i_useq_next_addr (
      .clk       (clk),
      .rst       (rst),
      .cond_in   (cond_in),
      .cond_sel  (cond_sel),
      .cond_pol  (cond_pol),
      .func      (func),
      .literal   (literal),
      .bus_data  (bus_data),
      .br_lo_stb (br_lo_stb),
      .br_hi_stb (br_hi_stb),
      .load_mode (load_mode),
      .addr_out  (addr_out)
   );

   task automatic chk(input string tag, input logic [11:0] exp);
      n_chk++;
      if (addr_out !== exp) begin
         n_bad++;
         $display("FAIL %s: addr_out actual=%h expected=%h", tag, addr_out, exp);
      end
   endtask

   // called at a falling edge; the result is visible at the next falling edge
   task automatic cyc(input logic [3:0] f, input logic [3:0] s, input logic p,
                      input logic [11:0] lit);
      func     = f;
      cond_sel = s;
      cond_pol = p;
      literal  = lit;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // cond_in = 0x0020: line 5 high, line 6 low
   task automatic t_reset_state();
      chk("R1 reset", 12'h000);
      cyc(4'd9, 4'd0, 1'b0, 12'h0);
      chk("R1 pop after reset", 12'h000);
   endtask

   task automatic t_continue();
      cyc(4'd0, 4'd0, 1'b0, 12'h0);
      cyc(4'd0, 4'd0, 1'b0, 12'h0);
      cyc(4'd0, 4'd0, 1'b0, 12'h0);
      chk("R3 continue", 12'h003);
      cyc(4'd1, 4'd0, 1'b0, 12'hFFF);
      chk("R4 jump literal", 12'hFFF);
      cyc(4'd0, 4'd0, 1'b0, 12'h0);
      chk("R3 wrap", 12'h000);
   endtask

   task automatic t_condition();
      cyc(4'd5, 4'd5, 1'b0, 12'h155);
      chk("R2 sel5 pol0 taken", 12'h155);
      cyc(4'd5, 4'd5, 1'b1, 12'h300);
      chk("R2 sel5 pol1 not taken", 12'h156);
      cyc(4'd5, 4'd6, 1'b1, 12'h300);
      chk("R2 sel6 pol1 taken", 12'h300);
      cyc(4'd5, 4'd6, 1'b0, 12'h155);
      chk("R5 literal not taken", 12'h301);
      cyc(4'd15, 4'd6, 1'b1, 12'h0);
      chk("R5 zero taken", 12'h000);
      cyc(4'd15, 4'd5, 1'b1, 12'h0);
      chk("R5 zero not taken", 12'h001);
   endtask

   task automatic t_branch();
      bus_data  = 8'h34;
      br_lo_stb = 1'b1;
      cyc(4'd0, 4'd0, 1'b0, 12'h0);
      br_lo_stb = 1'b0;
      bus_data  = 8'hFA;
      br_hi_stb = 1'b1;
      cyc(4'd0, 4'd0, 1'b0, 12'h0);
      br_hi_stb = 1'b0;
      bus_data  = 8'h77;
      cyc(4'd0, 4'd0, 1'b0, 12'h0);
      cyc(4'd2, 4'd0, 1'b0, 12'h0);
      chk("R9 branch register load", 12'hA34);
      cyc(4'd4, 4'd5, 1'b1, 12'h0);
      chk("R5 branch not taken", 12'hA35);
      cyc(4'd4, 4'd5, 1'b0, 12'h0);
      chk("R5 branch taken", 12'hA34);
      cyc(4'd3, 4'd0, 1'b0, 12'h0);
      chk("R4 jump zero", 12'h000);
   endtask

   task automatic t_call();
      cyc(4'd1, 4'd0, 1'b0, 12'h040);
      cyc(4'd6, 4'd5, 1'b1, 12'h200);
      chk("R12 call not taken", 12'h041);
      cyc(4'd6, 4'd5, 1'b0, 12'h200);
      chk("R6 call literal", 12'h200);
      cyc(4'd7, 4'd5, 1'b0, 12'h0);
      chk("R6 call branch", 12'hA34);
      cyc(4'd8, 4'd5, 1'b1, 12'h0);
      chk("R12 return not taken", 12'hA35);
      cyc(4'd8, 4'd5, 1'b0, 12'h0);
      chk("R6 return", 12'h201);
      cyc(4'd9, 4'd0, 1'b0, 12'h0);
      chk("R4 unconditional return", 12'h042);
   endtask

   task automatic t_misc();
      cyc(4'd12, 4'd5, 1'b1, 12'h0);
      chk("R11 wait hold", 12'h042);
      cyc(4'd12, 4'd5, 1'b0, 12'h0);
      chk("R11 wait release", 12'h043);
      cyc(4'd10, 4'd0, 1'b0, 12'h0);
      chk("R4 push continue", 12'h044);
      cyc(4'd1, 4'd0, 1'b0, 12'h300);
      cyc(4'd13, 4'd5, 1'b0, 12'h0);
      chk("R11 top of stack jump", 12'h044);
      cyc(4'd13, 4'd5, 1'b1, 12'h0);
      chk("R11 top of stack not taken", 12'h045);
      cyc(4'd11, 4'd5, 1'b1, 12'h0);
      chk("R12 discard not taken", 12'h046);
      cyc(4'd11, 4'd5, 1'b0, 12'h0);
      chk("R11 discard", 12'h047);
      cyc(4'd9, 4'd0, 1'b0, 12'h0);
      chk("R8 pop empty", 12'h044);
      cyc(4'd14, 4'd5, 1'b0, 12'h123);
      chk("R11 two-way true", 12'hA34);
      cyc(4'd14, 4'd5, 1'b1, 12'h123);
      chk("R11 two-way false", 12'h123);
   endtask

   task automatic t_overflow();
      do_reset();
      cyc(4'd1, 4'd0, 1'b0, 12'h010);
      cyc(4'd6, 4'd5, 1'b0, 12'h020);
      cyc(4'd6, 4'd5, 1'b0, 12'h030);
      cyc(4'd6, 4'd5, 1'b0, 12'h040);
      cyc(4'd6, 4'd5, 1'b0, 12'h050);
      cyc(4'd6, 4'd5, 1'b0, 12'h060);
      chk("R7 fifth call", 12'h060);
      cyc(4'd9, 4'd0, 1'b0, 12'h0);
      chk("R7 pop 1", 12'h051);
      cyc(4'd9, 4'd0, 1'b0, 12'h0);
      chk("R7 pop 2", 12'h041);
      cyc(4'd9, 4'd0, 1'b0, 12'h0);
      chk("R7 pop 3", 12'h031);
      cyc(4'd9, 4'd0, 1'b0, 12'h0);
      chk("R7 pop 4 oldest lost", 12'h021);
      cyc(4'd9, 4'd0, 1'b0, 12'h0);
      chk("R8 pop on empty", 12'h021);
   endtask

   task automatic t_load();
      cyc(4'd1, 4'd0, 1'b0, 12'h123);
      load_mode = 1'b1;
      cyc(4'd6, 4'd5, 1'b0, 12'h200);
      chk("R10 first write cycle", 12'h000);
      cyc(4'd6, 4'd5, 1'b0, 12'h200);
      chk("R10 second write cycle", 12'h001);
      cyc(4'd9, 4'd0, 1'b0, 12'h0);
      chk("R10 third write cycle", 12'h002);
      load_mode = 1'b0;
      cyc(4'd9, 4'd0, 1'b0, 12'h0);
      chk("R10 stack untouched", 12'h021);
      load_mode = 1'b1;
      cyc(4'd1, 4'd0, 1'b0, 12'h3FF);
      chk("R10 new load burst", 12'h000);
      load_mode = 1'b0;
   endtask

   initial begin
      rst       = 1'b1;
      cond_in   = 16'h0020;
      cond_sel  = '0;
      cond_pol  = 1'b0;
      func      = '0;
      literal   = '0;
      bus_data  = '0;
      br_lo_stb = 1'b0;
      br_hi_stb = 1'b0;
      load_mode = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      t_reset_state();
      t_continue();
      t_condition();
      t_branch();
      t_call();
      t_misc();
      t_overflow();
      t_load();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule